// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital control for a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock and divides it down to an internal tick. On that tick it steps through a fixed loop of four measurement phases: auto-zero, input integrate, reference de-integrate and integrator-output zero. Each phase has its own one-hot switch-enable output, which drives the analog switches around the integrator. The integrator, the comparator and the switches sit outside this block.

Auto-zero and integrate last equally long. Their length comes from an 8-bit load value: a smaller value gives a longer integration, so more resolution at a lower conversion rate. De-integrate ticks are counted until the comparator reports a zero crossing, or until the count reaches twice the integrate length. The sign, the overrange flag and the count are then placed in a held output register, together with a one-cycle valid pulse. An active-low end-of-conversion output is low for as long as the sequencer sits in auto-zero.

A halt input parks the sequencer in auto-zero. A load strobe installs a new load value and starts the loop again from the beginning.

Top module: `dual_slope_seq`

## Requirements
- R1: Phases run in the order auto-zero, integrate, de-integrate, output-zero, then back to auto-zero. `sw_en_o` is one-hot with bit 0 = auto-zero, bit 1 = integrate, bit 2 = de-integrate and bit 3 = output-zero.
- R2: The internal tick occurs once every DIV (default 4) clocks, and the phase changes only on a tick. A strobe or a halt clears the divider, so the next tick comes DIV clocks after the last clock edge at which either one was sampled high.
- R3: With load value L, auto-zero and integrate each last N = (256 − L) × UNIT_TICKS ticks, which is DIV × N clocks. With the defaults this is (256 − L) × 1024 clocks, and L = 0 gives 256 units.
- R4: The sign result equals `pol_i` as sampled on the final integrate tick.
- R5: De-integrate ends on the first of its ticks (numbered from 0) that sees `zc_i` high. The count is that tick's index and the overrange flag is 0.
- R6: If `zc_i` is still low on de-integrate tick 2N − 1, de-integrate ends there with overrange 1 and count 2N − 1.
- R7: While `halt_i` is high, the sequencer is in auto-zero from the next cycle on, stays there, and produces no result. After `halt_i` is released, a full auto-zero period of N ticks follows.
- R8: `eoc_n_o` is low exactly while the sequencer is in auto-zero.
- R9: When de-integrate ends, sign, overrange and count are registered and `res_vld_o` pulses high for one cycle, the first cycle of output-zero. At all other times the result outputs hold their values.
- R10: A `load_stb_i` pulse stores `load_val_i` and restarts in auto-zero. The following durations use the new value. If a strobe or a halt arrives on the tick that would end de-integrate, that conversion is dropped: no pulse, and the result is unchanged.
- R11: Output-zero ends on the first tick that sees `zc_i` high, or after IZ_TICKS ticks, whichever comes first.
- R12: Synchronous reset `rst_i` gives auto-zero, `eoc_n_o` low, all result fields zero, `res_vld_o` low, and a load value of RST_LOAD (default 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Hold the sequencer in auto-zero while high |
| zc_i | input | 1 | Comparator zero-crossing indication |
| pol_i | input | 1 | Integrator polarity |
| load_val_i | input | LOAD_W | New load value |
| load_stb_i | input | 1 | Accept `load_val_i` and restart |
| sw_en_o | output | 4 | One-hot phase switch enables |
| eoc_n_o | output | 1 | Active-low end of conversion |
| res_vld_o | output | 1 | One-cycle pulse when a new result is stored |
| res_sign_o | output | 1 | Stored sign |
| res_ovr_o | output | 1 | Stored overrange flag |
| res_cnt_o | output | CNT_W | Stored de-integrate count |

## Verification
The end of de-integrate can fall in the same cycle as a restart, either a load strobe or a halt. The bench raises the zero crossing so that it is seen on a chosen de-integrate tick, then asserts the strobe, or in a second run the halt, for exactly the clock edge of that tick. It passes the case only if no valid pulse appears, the held result keeps its previous values, the sequencer is back in auto-zero, and the next auto-zero lasts the full period for the load value then in force.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2,
        PH_IZ    = 2'd3
    } phase_t;

    typedef struct packed {
        logic sign;
        logic ovr;
    } res_flags_t;

    localparam int unsigned NUM_PHASES = 4;

    // ticks in one auto-zero or integrate period
    function automatic int unsigned period_ticks(input int unsigned load_val,
                                                 input int unsigned span,
                                                 input int unsigned unit);
        return (span - load_val) * unit;
    endfunction

endpackage

// File: rtl/dsc_tick_div.sv
module dsc_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i)  div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o);
            assert_restart_no_tick_R2: assert property (@(posedge clk_i) disable iff (rst_i)
                restart_i |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/dsc_phase_ctl.sv
module dsc_phase_ctl
    import dsc_pkg::*;
#(
    parameter int LOAD_W     = 8,
    parameter int UNIT_TICKS = 256,
    parameter int IZ_TICKS   = 256,
    parameter int CNT_W      = 17
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              halt_i,
    input  logic              restart_i,
    input  logic              tick_i,
    input  logic              zc_i,
    input  logic              pol_i,
    input  logic [LOAD_W-1:0] load_i,
    output phase_t            phase_o,
    output logic              done_o,
    output res_flags_t        done_flags_o,
    output logic [CNT_W-1:0]  done_cnt_o
);
    localparam int SPAN = 2 ** LOAD_W;
    localparam logic [CNT_W-1:0] IZ_LAST = CNT_W'(IZ_TICKS - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] ctr_q;
    logic             sign_q;
    logic [CNT_W:0]   n_w;
    logic [CNT_W:0]   one_w;
    logic [CNT_W-1:0] n_last;
    logic [CNT_W-1:0] lim_last;
    logic             flush;
    logic             deint_end;

    assign one_w    = (CNT_W+1)'(1);
    assign n_w      = (CNT_W+1)'(period_ticks(int'(load_i), SPAN, UNIT_TICKS));
    assign n_last   = CNT_W'(n_w - one_w);
    assign lim_last = CNT_W'((n_w << 1) - one_w);
    assign flush    = rst_i || halt_i || restart_i;
    assign deint_end = tick_i && (phase_q == PH_DEINT) && (zc_i || ctr_q == lim_last);

    always_ff @(posedge clk_i) begin
        if (rst_i) sign_q <= 1'b0;
        else if (!flush && tick_i && phase_q == PH_INT && ctr_q == n_last) sign_q <= pol_i;
    end

    always_ff @(posedge clk_i) begin
        if (flush) begin
            phase_q <= PH_AZ;
            ctr_q   <= '0;
        end else if (tick_i) begin
            unique case (phase_q)
                PH_AZ: begin
                    if (ctr_q == n_last) begin phase_q <= PH_INT; ctr_q <= '0; end
                    else ctr_q <= ctr_q + 1'b1;
                end
                PH_INT: begin
                    if (ctr_q == n_last) begin phase_q <= PH_DEINT; ctr_q <= '0; end
                    else ctr_q <= ctr_q + 1'b1;
                end
                PH_DEINT: begin
                    if (deint_end) begin phase_q <= PH_IZ; ctr_q <= '0; end
                    else ctr_q <= ctr_q + 1'b1;
                end
                PH_IZ: begin
                    if (zc_i || ctr_q == IZ_LAST) begin phase_q <= PH_AZ; ctr_q <= '0; end
                    else ctr_q <= ctr_q + 1'b1;
                end
                default: begin phase_q <= PH_AZ; ctr_q <= '0; end
            endcase
        end
    end

    assign phase_o           = phase_q;
    assign done_o            = deint_end && !flush;
    assign done_flags_o.sign = sign_q;
    assign done_flags_o.ovr  = !zc_i;
    assign done_cnt_o        = ctr_q;

    assert_order_az_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_AZ) |=> (phase_q == PH_AZ || phase_q == PH_INT));
    assert_order_int_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_INT) |=> (phase_q == PH_INT || phase_q == PH_DEINT || phase_q == PH_AZ));
    assert_order_deint_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_DEINT) |=> (phase_q == PH_DEINT || phase_q == PH_IZ || phase_q == PH_AZ));
    assert_order_iz_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_IZ) |=> (phase_q == PH_IZ || phase_q == PH_AZ));
    assert_phase_on_tick_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !halt_i && !restart_i) |=> $stable(phase_q));
    assert_halt_parks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_i |=> (phase_q == PH_AZ && ctr_q == '0));
    assert_deint_limit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_DEINT) |-> (ctr_q <= lim_last));

endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg
    import dsc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             done_i,
    input  res_flags_t       flags_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             vld_o,
    output res_flags_t       flags_o,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_o   <= 1'b0;
            flags_o <= '0;
            cnt_o   <= '0;
        end else begin
            vld_o <= done_i;
            if (done_i) begin
                flags_o <= flags_i;
                cnt_o   <= cnt_i;
            end
        end
    end

    assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_i |=> ($stable(cnt_o) && $stable(flags_o)));
    assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |=> !vld_o);

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsc_pkg::*;
#(
    parameter int LOAD_W     = 8,
    parameter int UNIT_TICKS = 256,
    parameter int DIV        = 4,
    parameter int IZ_TICKS   = 256,
    parameter int RST_LOAD   = 128,
    localparam int CNT_W     = $clog2(2 * (2 ** LOAD_W) * UNIT_TICKS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              halt_i,
    input  logic              zc_i,
    input  logic              pol_i,
    input  logic [LOAD_W-1:0] load_val_i,
    input  logic              load_stb_i,
    output logic [3:0]        sw_en_o,
    output logic              eoc_n_o,
    output logic              res_vld_o,
    output logic              res_sign_o,
    output logic              res_ovr_o,
    output logic [CNT_W-1:0]  res_cnt_o
);
    logic [LOAD_W-1:0] load_q;
    logic              tick;
    phase_t            phase;
    logic              done;
    res_flags_t        done_flags;
    res_flags_t        res_flags;
    logic [CNT_W-1:0]  done_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i)           load_q <= LOAD_W'(RST_LOAD);
        else if (load_stb_i) load_q <= load_val_i;
    end

    dsc_tick_div #(.DIV(DIV)) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (load_stb_i || halt_i),
        .tick_o    (tick)
    );

    dsc_phase_ctl #(
        .LOAD_W     (LOAD_W),
        .UNIT_TICKS (UNIT_TICKS),
        .IZ_TICKS   (IZ_TICKS),
        .CNT_W      (CNT_W)
    ) u_ctl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .halt_i       (halt_i),
        .restart_i    (load_stb_i),
        .tick_i       (tick),
        .zc_i         (zc_i),
        .pol_i        (pol_i),
        .load_i       (load_q),
        .phase_o      (phase),
        .done_o       (done),
        .done_flags_o (done_flags),
        .done_cnt_o   (done_cnt)
    );

    dsc_result_reg #(.CNT_W(CNT_W)) u_res (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .done_i  (done),
        .flags_i (done_flags),
        .cnt_i   (done_cnt),
        .vld_o   (res_vld_o),
        .flags_o (res_flags),
        .cnt_o   (res_cnt_o)
    );

    generate
        for (genvar g = 0; g < NUM_PHASES; g++) begin : g_sw
            assign sw_en_o[g] = (phase == phase_t'(g));
        end
    endgenerate

    assign eoc_n_o    = (phase != PH_AZ);
    assign res_sign_o = res_flags.sign;
    assign res_ovr_o  = res_flags.ovr;

    assert_switch_onehot_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(sw_en_o) == 1);
    assert_valid_in_iz_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        res_vld_o |-> (sw_en_o[3] && eoc_n_o));
    assert_strobe_restart_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        load_stb_i |=> (sw_en_o[0] && !eoc_n_o && !res_vld_o));
    assert_halt_no_result_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_i |=> !res_vld_o);
    assert_eoc_low_az_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(eoc_n_o) |-> sw_en_o[0]);

endmodule

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;

    localparam int TB_UNIT = 4;
    localparam int TB_IZ   = 16;
    localparam int TB_CW   = $clog2(2 * 256 * TB_UNIT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt = 1'b0;
    logic zc = 1'b0;
    logic pol = 1'b0;
    logic [7:0] ld_val = '0;
    logic ld_stb = 1'b0;
    logic [3:0] sw;
    logic eoc_n, vld, sgn, ovr;
    logic [TB_CW-1:0] cnt;

    int n_checks = 0;
    int n_fail = 0;
    int cur_n = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    dual_slope_seq #(.UNIT_TICKS(TB_UNIT), .IZ_TICKS(TB_IZ)) i_dual_slope_seq (
        .clk_i(clk), .rst_i(rst), .halt_i(halt), .zc_i(zc), .pol_i(pol),
        .load_val_i(ld_val), .load_stb_i(ld_stb), .sw_en_o(sw), .eoc_n_o(eoc_n),
        .res_vld_o(vld), .res_sign_o(sgn), .res_ovr_o(ovr), .res_cnt_o(cnt)
    );

    function automatic int n_of(input int l);
        return (256 - l) * TB_UNIT;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_load(input int l);
        @(negedge clk);
        ld_val = 8'(l); ld_stb = 1'b1;
        @(negedge clk);
        ld_stb = 1'b0;
        cur_n = n_of(l);
        chk(sw == 4'b0001, "R10 strobe restarts in auto-zero", sw, 1);
    endtask

    task automatic run_az();
        int c = 0; bit eoc_bad = 0;
        while (sw == 4'b0001) begin
            if (eoc_n !== 1'b0) eoc_bad = 1;
            c++;
            @(negedge clk);
        end
        chk(c == 4 * cur_n, "R3 auto-zero clocks", c, 4 * cur_n);
        chk(!eoc_bad && eoc_n == 1'b1, "R8 eoc low only in auto-zero", eoc_n, 1);
        chk(sw == 4'b0010, "R1 integrate follows auto-zero", sw, 2);
    endtask

    task automatic run_int(input bit p);
        int c = 0;
        pol = p;
        while (sw == 4'b0010) begin c++; @(negedge clk); end
        chk(c == 4 * cur_n, "R3 integrate clocks", c, 4 * cur_n);
        chk(sw == 4'b0100, "R1 de-integrate follows integrate", sw, 4);
        pol = ~p;
    endtask

    task automatic run_conv(input bit p, input int k, input int j);
        int m = 0; int i = 0; int em; int ei; int ecnt; bit eovr;
        logic [TB_CW-1:0] hcnt; logic hs, ho;
        run_az();
        run_int(p);
        while (!vld) begin
            if (k >= 0 && m == 4 * k + 1) zc = 1'b1;
            @(negedge clk); m++;
        end
        zc = 1'b0;
        if (k >= 0 && k < 2 * cur_n) begin em = 4 * k + 4; ecnt = k; eovr = 0; end
        else begin em = 8 * cur_n; ecnt = 2 * cur_n - 1; eovr = 1; end
        chk(m == em, "R5/R6 de-integrate clocks", m, em);
        chk(cnt == TB_CW'(ecnt), eovr ? "R6 overrange count" : "R5 count", cnt, ecnt);
        chk(ovr == eovr, "R6 overrange flag", ovr, eovr);
        chk(sgn == p, "R4 sign", sgn, p);
        chk(sw == 4'b1000, "R9 valid in first output-zero cycle", sw, 8);
        hcnt = cnt; hs = sgn; ho = ovr;
        while (sw == 4'b1000) begin
            if (i == 1) chk(vld == 1'b0, "R9 valid lasts one cycle", vld, 0);
            if (j >= 0 && i == 4 * j + 1) zc = 1'b1;
            @(negedge clk); i++;
        end
        zc = 1'b0;
        ei = (j >= 0 && j < TB_IZ) ? 4 * j + 4 : 4 * TB_IZ;
        chk(i == ei, "R11 output-zero clocks", i, ei);
        chk(sw == 4'b0001, "R1 auto-zero follows output-zero", sw, 1);
        chk(cnt == hcnt && sgn == hs && ovr == ho, "R9 result held", cnt, hcnt);
    endtask

    task automatic coincide(input bit use_halt, input int k, input int new_l);
        int m = 0;
        logic [TB_CW-1:0] hcnt; logic hs, ho;
        hcnt = cnt; hs = sgn; ho = ovr;
        run_az();
        run_int(1'b1);
        while (m < 4 * k + 3) begin
            if (m == 4 * k + 1) zc = 1'b1;
            @(negedge clk); m++;
        end
        if (use_halt) halt = 1'b1;
        else begin ld_val = 8'(new_l); ld_stb = 1'b1; end
        @(negedge clk);
        halt = 1'b0; ld_stb = 1'b0; zc = 1'b0;
        if (!use_halt) cur_n = n_of(new_l);
        chk(vld == 1'b0, use_halt ? "R10 halt on final tick: no valid" : "R10 strobe on final tick: no valid", vld, 0);
        chk(sw == 4'b0001, "R10 back in auto-zero", sw, 1);
        chk(cnt == hcnt && sgn == hs && ovr == ho, "R10 dropped result leaves output", cnt, hcnt);
        run_conv(1'b0, 3, -1);
    endtask

    initial begin : watchdog
        while (!done_flag) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
                summary();
            end
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(sw == 4'b0001 && eoc_n == 1'b0, "R12 reset phase", sw, 1);
        chk(vld == 0 && cnt == 0 && sgn == 0 && ovr == 0, "R12 reset result", cnt, 0);
        rst = 1'b0;
        cur_n = n_of(128);
        run_conv(1'b1, 5, 2);            // R12 default load value timing

        do_load(255);                    // R3 shortest period
        run_conv(1'b0, 0, 0);            // R5 crossing on first tick, R11 early end
        run_conv(1'b1, -1, -1);          // R6 overrange, R11 timeout
        run_conv(1'b0, 2 * cur_n - 1, 3);// R5 crossing on last allowed tick

        do_load(250);
        begin : halt_case                // R7
            bit stay_ok = 1;
            run_az();
            pol = 1'b1;
            repeat (5) @(negedge clk);
            halt = 1'b1;
            @(negedge clk);
            chk(sw == 4'b0001 && eoc_n == 1'b0, "R7 halt forces auto-zero", sw, 1);
            repeat (8) begin
                @(negedge clk);
                if (sw != 4'b0001 || vld) stay_ok = 0;
            end
            chk(stay_ok, "R7 stays in auto-zero while halted", sw, 1);
            halt = 1'b0;
            run_conv(1'b1, 4, -1);
        end

        coincide(1'b0, 2, 252);          // R10 strobe on final tick
        coincide(1'b1, 1, 0);            // R10 halt on final tick

        for (int r = 0; r < 12; r++) begin
            int l = 236 + int'($urandom % 20);
            int k;
            if (r % 3 == 0) do_load(l);
            k = int'($urandom % (2 * cur_n + 2));
            if (k >= 2 * cur_n) k = -1;
            run_conv(1'($urandom), k, int'($urandom % (TB_IZ + 2)) - 1);
        end

        do_load(0);                      // R3 load 0 gives 256 units
        run_conv(1'b1, -1, 1);

        done_flag = 1'b1;
        summary();
    end

endmodule